// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending half of a small byte-wide serial port that a processor drives through two bus addresses. One address reads back a status byte. The other accepts the byte to be sent. A written byte first goes into a one-entry holding register. It then moves into a separate shift register, which drives a single output line with asynchronous frames. Each frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. A free-running clock-enable divider sets the bit period.

The holding register is released the moment its byte moves into the shift register, not when the frame ends. Software can therefore queue the next byte while the current one is still on the line. A program that echoes characters can keep the line busy without gaps as long as it refills the holding register within one frame time.

The port has no flow-control lines. It does not pause for any in-band characters. Reception is handled elsewhere.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset the line output is high, and the status byte reads 0x06: bit 1 (holding empty) and bit 2 (shifter idle) are set, all other bits are clear.
- R2: Each byte is sent as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts exactly BAUD_DIV clock cycles, and the line idles high.
- R3: A write with `reg_sel`=1 while the holding register is empty stores the byte. From the next cycle, status bit 1 reads 0.
- R4: Status bit 1 returns to 1 as soon as the held byte moves into the shift register, while that byte is still being sent.
- R5: A write with `reg_sel`=1 while the holding register is full is ignored. The pending byte is the one later sent, unchanged.
- R6: If the holding register is full when a stop bit ends, the next start bit follows at once. Start bits of such frames are exactly 10*BAUD_DIV cycles apart.
- R7: Status bit 2 is 1 exactly when the shift register is not sending a frame.
- R8: A write with `reg_sel`=0 (the status/control address) loads nothing. The status byte and the line do not change. Reading with `reg_sel`=1 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 status/control, 1 data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; status byte when `reg_sel`=0 |
| tx_o | output | 1 | Serial line output |

## Verification
The hardest state to reach is a holding register refilled while a frame is still shifting, and then found full by the shifter exactly at the stop-bit tick. Only that state shows the gap-free hand-over. It is also the only window in which a write to a full register can be attempted. The stimulus polls the status byte until bit 1 rises mid-frame, writes immediately, and then writes again before the hand-over. A behavioural model and a line decoder check the spacing of start bits and which bytes reach the line.

// File: rtl/dbuf_uart_tx_pkg.sv
// Package: shared constants for the double-buffered transmitter.
// Assumes an 8N1-style frame built from DATA_W data bits.
package dbuf_uart_tx_pkg;
    localparam int STAT_EMPTY_BIT = 1;   // holding register empty
    localparam int STAT_IDLE_BIT  = 2;   // shift register not sending
    localparam logic REG_STATUS   = 1'b0;
    localparam logic REG_DATA     = 1'b1;
endpackage

// File: rtl/tx_baud_gen.sv
// Module: tx_baud_gen
// Produces a one-cycle enable every DIV clocks. Free-running from reset.
// Assumes DIV >= 1.
module tx_baud_gen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    // Flag the final count of each period.
    assign tick = (cnt == CNT_W'(DIV - 1));

    // Count clock cycles and wrap at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_tick_chk
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tx_hold_reg.sv
// Module: tx_hold_reg
// One-entry holding register. It accepts a byte only while empty and
// empties when the shift register takes the byte.
// Assumes load_req and take never both hit a full/empty conflict.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Accept a byte only when empty; release it on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (load_req && !full) begin
            full <= 1'b1;
            data <= load_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !full) |=> full);
    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/tx_shifter.sv
// Module: tx_shifter
// Frames and shifts one byte per frame onto the line. On a bit tick it
// loads from the holding register when idle, or right after a stop bit.
// Assumes tick is a one-cycle enable.
module tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              tx
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] sr;
    logic [BIT_W-1:0]      bit_cnt;
    logic                  last_bit;

    // Decode the stop-bit position.
    assign last_bit = (bit_cnt == BIT_W'(FRAME_BITS - 1));
    // Take a byte when idle, or at the end of a frame, if one is waiting.
    assign take     = tick && hold_full && (!busy || last_bit);
    // The line idles high.
    assign tx       = busy ? sr[0] : 1'b1;

    // Load a fresh frame or step to the next bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '1;
            bit_cnt <= '0;
            busy    <= 1'b0;
        end else if (take) begin
            sr      <= {1'b1, hold_data, 1'b0};
            bit_cnt <= '0;
            busy    <= 1'b1;
        end else if (tick && busy) begin
            if (last_bit) begin
                busy <= 1'b0;
            end else begin
                sr      <= {1'b1, sr[FRAME_BITS-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx));
    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && last_bit && hold_full) |=> (busy && !tx));
endmodule

// File: rtl/dbuf_uart_tx.sv
// Module: dbuf_uart_tx (top)
// Bus-facing transmitter: a status address, a data address, a holding
// stage and a shift stage. Assumes one-cycle write strobes.
module dbuf_uart_tx #(
    parameter int DATA_W   = 8,
    parameter int BAUD_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_o
);
    import dbuf_uart_tx_pkg::*;

    logic              tick;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              data_wr;

    // Decode writes to the data address.
    assign data_wr = wr_en && (reg_sel == REG_DATA);

    tx_baud_gen #(.DIV(BAUD_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_req(data_wr), .load_data(wdata),
        .take(take), .full(hold_full), .data(hold_data)
    );

    tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full),
        .hold_data(hold_data), .take(take), .busy(busy), .tx(tx_o)
    );

    // Build the read data: status byte at the status address, zero otherwise.
    always_comb begin
        rdata = '0;
        if (reg_sel == REG_STATUS) begin
            rdata[STAT_EMPTY_BIT] = !hold_full;
            rdata[STAT_IDLE_BIT]  = !busy;
        end
    end

    // R4
    release_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!hold_full && busy));
    // R8
    status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_STATUS && !hold_full && !take) |=> !hold_full);
endmodule

// File: tb/dbuf_uart_tx_tb.sv
module dbuf_uart_tx_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tx_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dbuf_uart_tx #(.DATA_W(8), .BAUD_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .tx_o(tx_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    int   m_div = 0, m_busy = 0, m_bit = 0, m_full = 0;
    logic [7:0] m_hold = 0, m_byte = 0;

    function automatic logic exp_tx();
        if (!m_busy) return 1'b1;
        if (m_bit == 0) return 1'b0;
        if (m_bit == 9) return 1'b1;
        return m_byte[m_bit-1];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_busy = 0; m_bit = 0; m_full = 0; m_hold = 0;
        end else begin
            bit t, tk;
            int old_full;
            t = (m_div == DIV - 1);
            m_div = t ? 0 : m_div + 1;
            old_full = m_full;
            tk = t && old_full && (!m_busy || m_bit == 9);
            if (tk) begin
                m_busy = 1; m_bit = 0; m_byte = m_hold; m_full = 0;
            end else if (t && m_busy) begin
                if (m_bit == 9) m_busy = 0; else m_bit++;
            end
            if (wr_en && reg_sel && !old_full) begin
                m_hold = wdata; m_full = 1;
            end
        end
    end

    // Compare line and read data every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] es;
            es = 8'h00;
            if (!reg_sel) es = {5'b0, (m_busy == 0), (m_full == 0), 1'b0};
            check(tx_o === exp_tx(), "R2 R6 line", tx_o, exp_tx());
            check(rdata === es, "R4 R7 status", rdata, es);
        end
    end

    // Line decoder
    logic [7:0] got[$];
    int starts[$];
    int ph = 0;
    bit rx_busy = 0;
    logic [7:0] rx_sh;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rx_busy) begin
                if (tx_o === 1'b0) begin
                    rx_busy = 1; ph = 0; starts.push_back(cyc);
                end
            end else begin
                ph++;
                for (int k = 1; k <= 8; k++)
                    if (ph == k*DIV + DIV/2) rx_sh[k-1] = tx_o;
                if (ph == 9*DIV + DIV/2) begin
                    check(tx_o === 1'b1, "R2 stop bit", tx_o, 1);
                    got.push_back(rx_sh);
                    rx_busy = 0;
                end
            end
        end
    end

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(posedge clk); #1;
        reg_sel = sel; wr_en = 1'b1; wdata = d;
        @(posedge clk); #1;
        reg_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        @(negedge clk);
        while (rdata[1] !== 1'b1) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_o === 1'b1, "R1 line idle", tx_o, 1);
        check(rdata === 8'h06, "R1 status", rdata, 8'h06);

        // R8 write to status address loads nothing
        bus_write(1'b0, 8'h55);
        repeat (3*DIV) @(negedge clk);
        check(rdata === 8'h06, "R8 status unchanged", rdata, 8'h06);
        check(tx_o === 1'b1, "R8 line unchanged", tx_o, 1);
        reg_sel = 1'b1; #1;
        check(rdata === 8'h00, "R8 data address reads zero", rdata, 0);
        reg_sel = 1'b0;

        // R3 accept into empty register
        bus_write(1'b1, 8'hA5);
        @(negedge clk);
        check(rdata[1] === 1'b0, "R3 holding full", rdata[1], 0);

        // R4 freed while frame still in progress
        wait_empty();
        check(rdata[2] === 1'b0, "R4 empty while shifting", rdata[2], 0);
        // R7 shifter busy
        check(tx_o === 1'b0, "R7 start bit on line", tx_o, 0);

        // Refill mid-frame, then try to overwrite (R5)
        bus_write(1'b1, 8'h3C);
        bus_write(1'b1, 8'h81);
        wait_empty();
        bus_write(1'b1, 8'h00);
        wait_empty();
        bus_write(1'b1, 8'hFF);
        @(negedge clk);
        while (rdata !== 8'h06) @(negedge clk);
        repeat (2*DIV) @(negedge clk);
        // R7 fully idle at end
        check(rdata === 8'h06, "R7 idle status", rdata, 8'h06);

        // R2 R5 bytes on the line
        check(got.size() == 4, "R2 frame count", got.size(), 4);
        if (got.size() == 4) begin
            check(got[0] == 8'hA5, "R2 byte0", got[0], 8'hA5);
            check(got[1] == 8'h3C, "R5 byte1 kept", got[1], 8'h3C);
            check(got[2] == 8'h00, "R2 byte2", got[2], 8'h00);
            check(got[3] == 8'hFF, "R2 byte3", got[3], 8'hFF);
        end
        // R6 no gap between frames
        if (starts.size() == 4) begin
            for (int i = 1; i < 4; i++)
                check(starts[i] - starts[i-1] == 10*DIV, "R6 start spacing",
                      starts[i] - starts[i-1], 10*DIV);
        end else begin
            check(0, "R6 start count", starts.size(), 4);
        end
        finish_run();
    end
endmodule